// File: doc/BRIEF.md
# Closed-Loop Fan Duty Regulator

This block decides the 8-bit duty value that a downstream PWM generator turns into a fan drive waveform. The host selects one of two behaviours with a 2-bit mode field. In direct-duty mode the duty written by the host goes straight to the output, except that very small duties are cut to zero when tachometer measurement is enabled and the tach-mode bit is clear. In speed-regulation mode the block keeps its own duty register and moves it by a small step at fixed intervals, so that a measured tachometer count converges on a host target count.

Regulation is paced by a 1 ms tick input. Every 1000 ticks (or every 250 ticks when the fast-select bit is set) the block compares the most recent tach count against the target. It raises the duty when the count is more than 10 above the target, lowers it when the count is more than 10 below, and otherwise leaves it alone. A count is used only once: the measurement pipeline must deliver a fresh valid strobe between two updates, or the update does nothing. With the tach-mode bit clear, the duty never goes below a 30% floor in regulation mode.

Top module: `fan_duty_regulator`

## Requirements
- R1: While reset is high, and on the first cycle after it, `duty_out` is 0.
- R2: With mode code 00, 10 or 11, `duty_out` equals `host_duty` one clock later, subject only to R3.
- R3: In those modes, when `tach_en`=1, `tach_mode`=0 and `host_duty` < 18, `duty_out` is 0; when `tach_en`=0 or `tach_mode`=1, any `host_duty` (including 0..17) passes through unchanged.
- R4: With mode code 01 and `tach_en`=1, a regulation update happens every 1000 ticks when `fast_sel`=0 and every 250 ticks when `fast_sel`=1; the first update is applied at clock edge L+1 after entry (L the interval), and the result reaches `duty_out` one edge later.
- R5: At an update, the duty rises by one step when `meas_cnt` > `target_cnt`+10 and falls by one step when `meas_cnt` < `target_cnt`−10 (counts taken as unsigned 16-bit).
- R6: At an update, when |`meas_cnt`−`target_cnt`| ≤ 10, the duty is unchanged.
- R7: `step_sel` codes 00, 01, 10, 11 give steps of 1, 2, 4, 8; the result saturates at 0 and at 255.
- R8: An update acts only on a count whose `meas_valid` strobe came after the previous update; a strobe in the same cycle as an update is kept for the next update.
- R9: In mode 01 with `tach_en`=0, the regulated duty and `duty_out` hold their values.
- R10: In mode 01 with `tach_mode`=0, `duty_out` is at least 77 and each update result is raised to 77 if lower; with `tach_mode`=1 no floor applies.
- R11: On switching into mode 01, the regulated duty starts from the `host_duty` value present before the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 direct duty, 01 speed regulation, 10/11 treated as direct |
| tach_en | input | 1 | Tachometer measurement enabled |
| tach_mode | input | 1 | 1 disables the low-duty cutoff and the regulation floor |
| fast_sel | input | 1 | 1 selects the 250-tick interval, 0 the 1000-tick interval |
| step_sel | input | 2 | Step size code for regulation |
| host_duty | input | 8 | Host duty, 255 = 100% |
| target_cnt | input | 16 | Target tach count |
| meas_cnt | input | 16 | Measured tach count |
| meas_valid | input | 1 | One-cycle strobe marking a new `meas_cnt` |
| tick_ms | input | 1 | 1 ms timebase pulse |
| duty_out | output | 8 | Duty value for the PWM generator |

## Verification
The two functions that can meet in one cycle are the arrival of a new tach sample and the periodic update that consumes the previous one. The bench first lets an update consume a sample, then counts cycles from mode entry so that the next `meas_valid` pulse lands on the very edge where the update fires. It judges the result at the ports: that update must leave `duty_out` unchanged, since no fresh sample existed before it, and the following update must move the duty by one step using the coincident sample.

// File: rtl/fan_reg_pkg.sv
package fan_reg_pkg;

    localparam int DUTY_W = 8;
    localparam int CNT_W  = 16;
    localparam int DUTY_MAX = (1 << DUTY_W) - 1;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'b00,
        MODE_SPEED  = 2'b01,
        MODE_RSV_A  = 2'b10,
        MODE_RSV_B  = 2'b11
    } fan_mode_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10
    } step_dir_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             fresh;
    } tach_sample_t;

    function automatic logic [DUTY_W-1:0] step_amount(input logic [1:0] code);
        return DUTY_W'(1) << code;
    endfunction

    function automatic logic [DUTY_W-1:0] sat_add(input logic [DUTY_W-1:0] a,
                                                  input logic [DUTY_W-1:0] b);
        logic [DUTY_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[DUTY_W] ? DUTY_W'(DUTY_MAX) : s[DUTY_W-1:0];
    endfunction

    function automatic logic [DUTY_W-1:0] sat_sub(input logic [DUTY_W-1:0] a,
                                                  input logic [DUTY_W-1:0] b);
        return (a < b) ? '0 : (a - b);
    endfunction

    function automatic logic [DUTY_W-1:0] apply_floor(input logic [DUTY_W-1:0] d,
                                                      input logic [DUTY_W-1:0] floor_v,
                                                      input logic            en);
        return (en && d < floor_v) ? floor_v : d;
    endfunction

endpackage

// File: rtl/fan_interval_timer.sv
module fan_interval_timer #(
    parameter int TICKS_SLOW = 1000,
    parameter int TICKS_FAST = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic fast,
    input  logic tick,
    output logic update
);
    localparam int CW = $clog2(TICKS_SLOW + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = fast ? CW'(TICKS_FAST - 1) : CW'(TICKS_SLOW - 1);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt    <= '0;
            update <= 1'b0;
        end else begin
            update <= 1'b0;
            if (tick) begin
                if (cnt >= limit) begin
                    cnt    <= '0;
                    update <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_UPDATE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        update |=> !update); // R4

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(TICKS_SLOW - 1)); // R4

    AST_IDLE_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !active |=> !update); // R9

endmodule

// File: rtl/fan_tach_capture.sv
module fan_tach_capture
    import fan_reg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             valid,
    input  logic [CNT_W-1:0] count,
    input  logic             consume,
    output tach_sample_t     smp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            smp <= '0;
        end else begin
            if (valid) begin
                smp.count <= count;
            end
            if (!active) begin
                smp.fresh <= 1'b0;
            end else if (valid) begin
                smp.fresh <= 1'b1;
            end else if (consume) begin
                smp.fresh <= 1'b0;
            end
        end
    end

    AST_STROBE_MARKS_FRESH: assert property (@(posedge clk) disable iff (rst)
        (active && valid) |=> smp.fresh); // R8

    AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (consume && !valid) |=> !smp.fresh); // R8

endmodule

// File: rtl/fan_step_core.sv
module fan_step_core
    import fan_reg_pkg::*;
#(
    parameter int DEADBAND = 10,
    parameter int FLOOR    = 77
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DUTY_W-1:0] host_duty,
    input  logic              update,
    input  tach_sample_t      smp,
    input  logic [CNT_W-1:0]  target,
    input  logic [1:0]        step_code,
    input  logic              floor_en,
    output logic [DUTY_W-1:0] reg_duty
);
    localparam logic signed [CNT_W:0] BAND = (CNT_W+1)'(DEADBAND);

    logic signed [CNT_W:0] diff;
    step_dir_e             dir;
    logic [DUTY_W-1:0]     stepped;
    logic [DUTY_W-1:0]     next_duty;
    logic                  apply;

    always_comb begin
        diff = $signed({1'b0, smp.count}) - $signed({1'b0, target});
        if (diff > BAND) begin
            dir = DIR_UP;
        end else if (diff < -BAND) begin
            dir = DIR_DOWN;
        end else begin
            dir = DIR_HOLD;
        end
    end

    always_comb begin
        unique case (dir)
            DIR_UP:   stepped = sat_add(reg_duty, step_amount(step_code));
            DIR_DOWN: stepped = sat_sub(reg_duty, step_amount(step_code));
            default:  stepped = reg_duty;
        endcase
        next_duty = apply_floor(stepped, DUTY_W'(FLOOR), floor_en);
    end

    assign apply = update && smp.fresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_duty <= '0;
        end else if (load) begin
            reg_duty <= host_duty;
        end else if (apply) begin
            reg_duty <= next_duty;
        end
    end

    AST_HOLD_BETWEEN_UPDATES: assert property (@(posedge clk) disable iff (rst)
        (!load && !update) |=> $stable(reg_duty)); // R9

    AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!load && update && smp.fresh && !floor_en
         && ({1'b0, smp.count} <= {1'b0, target} + (CNT_W+1)'(DEADBAND))
         && ({1'b0, target} <= {1'b0, smp.count} + (CNT_W+1)'(DEADBAND)))
        |=> $stable(reg_duty)); // R6

    AST_STALE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (!load && update && !smp.fresh) |=> $stable(reg_duty)); // R8

endmodule

// File: rtl/fan_duty_regulator.sv
module fan_duty_regulator
    import fan_reg_pkg::*;
#(
    parameter int TICKS_SLOW = 1000,
    parameter int TICKS_FAST = 250,
    parameter int DEADBAND   = 10,
    parameter int CUTOFF     = 18,
    parameter int FLOOR      = 77
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              tach_en,
    input  logic              tach_mode,
    input  logic              fast_sel,
    input  logic [1:0]        step_sel,
    input  logic [DUTY_W-1:0] host_duty,
    input  logic [CNT_W-1:0]  target_cnt,
    input  logic [CNT_W-1:0]  meas_cnt,
    input  logic              meas_valid,
    input  logic              tick_ms,
    output logic [DUTY_W-1:0] duty_out
);
    fan_mode_e         mode_e;
    logic              speed;
    logic              active;
    logic              update;
    tach_sample_t      smp;
    logic [DUTY_W-1:0] reg_duty;
    logic [DUTY_W-1:0] out_next;

    assign mode_e = fan_mode_e'(mode);
    assign speed  = (mode_e == MODE_SPEED);
    assign active = speed && tach_en;

    fan_interval_timer #(
        .TICKS_SLOW(TICKS_SLOW),
        .TICKS_FAST(TICKS_FAST)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .active(active),
        .fast  (fast_sel),
        .tick  (tick_ms),
        .update(update)
    );

    fan_tach_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .valid  (meas_valid),
        .count  (meas_cnt),
        .consume(update),
        .smp    (smp)
    );

    fan_step_core #(
        .DEADBAND(DEADBAND),
        .FLOOR   (FLOOR)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (!speed),
        .host_duty(host_duty),
        .update   (update),
        .smp      (smp),
        .target   (target_cnt),
        .step_code(step_sel),
        .floor_en (!tach_mode),
        .reg_duty (reg_duty)
    );

    always_comb begin
        if (speed) begin
            out_next = apply_floor(reg_duty, DUTY_W'(FLOOR), !tach_mode);
        end else if (tach_en && !tach_mode && host_duty < DUTY_W'(CUTOFF)) begin
            out_next = '0;
        end else begin
            out_next = host_duty;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_out <= '0;
        end else begin
            duty_out <= out_next;
        end
    end

    AST_SPEED_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (speed && !tach_mode) |=> (duty_out >= DUTY_W'(FLOOR))); // R10

    AST_DIRECT_CUTOFF: assert property (@(posedge clk) disable iff (rst)
        (!speed && tach_en && !tach_mode && host_duty < DUTY_W'(CUTOFF))
        |=> (duty_out == '0)); // R3

    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
        (!speed && (tach_mode || !tach_en)) |=> (duty_out == $past(host_duty))); // R2

endmodule

// File: tb/sim_fan_duty_regulator.sv
module sim_fan_duty_regulator;

    localparam int CLK_PERIOD = 10;
    localparam int L_SLOW = 1000;
    localparam int L_FAST = 250;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        tach_en = 1'b0;
    logic        tach_mode = 1'b0;
    logic        fast_sel = 1'b1;
    logic [1:0]  step_sel = 2'b00;
    logic [7:0]  host_duty = 8'd200;
    logic [15:0] target_cnt = 16'd0;
    logic [15:0] meas_cnt = 16'd0;
    logic        meas_valid = 1'b0;
    logic        tick_ms = 1'b1;
    logic [7:0]  duty_out;

    int n_checks = 0;
    int n_fail = 0;
    int t = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fan_duty_regulator u0 (
        .clk(clk), .rst(rst), .mode(mode), .tach_en(tach_en),
        .tach_mode(tach_mode), .fast_sel(fast_sel), .step_sel(step_sel),
        .host_duty(host_duty), .target_cnt(target_cnt), .meas_cnt(meas_cnt),
        .meas_valid(meas_valid), .tick_ms(tick_ms), .duty_out(duty_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: duty_out=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_to(input int n);
        while (t < n) begin
            @(negedge clk);
            t++;
        end
    endtask

    function automatic int exp_direct(input int h, input bit en, input bit tm);
        return (en && !tm && h < 18) ? 0 : h;
    endfunction

    function automatic int exp_floor(input int d, input bit tm);
        return (!tm && d < 77) ? 77 : d;
    endfunction

    function automatic int exp_next(input int d, input int code, input int meas,
                                    input int tgt, input bit tm);
        int s = 1 << code;
        int r = d;
        if (meas > tgt + 10) r = d + s;
        else if (meas < tgt - 10) r = d - s;
        if (r > 255) r = 255;
        if (r < 0) r = 0;
        return exp_floor(r, tm);
    endfunction

    task automatic enter_speed(input int host, input int code, input bit tm,
                               input bit fast, input int tgt);
        @(negedge clk);
        mode = 2'b00; host_duty = 8'(host); tach_en = 1'b1; tach_mode = tm;
        fast_sel = fast; step_sel = 2'(code); target_cnt = 16'(tgt);
        meas_valid = 1'b0;
        repeat (3) @(negedge clk);
        mode = 2'b01;
        t = 0;
    endtask

    task automatic strobe_at(input int n, input int meas);
        wait_to(n);
        meas_cnt = 16'(meas);
        meas_valid = 1'b1;
        wait_to(n + 1);
        meas_valid = 1'b0;
    endtask

    // Two regulation updates, each with a fresh sample
    task automatic reg_round(input int host, input int code, input bit tm, input bit fast,
                             input int tgt, input int m1, input int m2, input string req);
        int L = fast ? L_FAST : L_SLOW;
        int d0, d1, d2;
        enter_speed(host, code, tm, fast, tgt);
        d0 = exp_floor(host, tm);
        wait_to(2);
        check("R11", duty_out, d0);
        strobe_at(2, m1);
        d1 = exp_next(host, code, m1, tgt, tm);
        wait_to(L + 1);
        check("R4", duty_out, d0);
        wait_to(L + 4);
        check(req, duty_out, d1);
        strobe_at(L + 6, m2);
        d2 = exp_next(d1, code, m2, tgt, tm);
        wait_to(2 * L + 4);
        check(req, duty_out, d2);
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", duty_out, 0);
        rst = 1'b0;
        check("R1", duty_out, 0);
        @(negedge clk);
        check("R2", duty_out, 200);

        // R3 directed cutoff corners
        @(negedge clk); tach_en = 1; tach_mode = 0; host_duty = 8'd17;
        @(negedge clk); check("R3", duty_out, 0);
        host_duty = 8'd18;
        @(negedge clk); check("R3", duty_out, 18);
        host_duty = 8'd17; tach_mode = 1;
        @(negedge clk); check("R3", duty_out, 17);
        tach_mode = 0; tach_en = 0;
        @(negedge clk); check("R3", duty_out, 17);
        mode = 2'b10; tach_en = 1; host_duty = 8'd5;
        @(negedge clk); check("R3", duty_out, 0);

        // R2/R3 random direct vectors
        for (int i = 0; i < 300; i++) begin
            int h;
            bit en, tm;
            int mc;
            h = $urandom % 256;
            if (i % 3 == 0) h = $urandom % 24;
            en = 1'($urandom % 2);
            tm = 1'($urandom % 2);
            mc = $urandom % 3;
            mode = (mc == 0) ? 2'b00 : (mc == 1) ? 2'b10 : 2'b11;
            host_duty = 8'(h); tach_en = en; tach_mode = tm;
            @(negedge clk);
            check("R2", duty_out, exp_direct(h, en, tm));
        end

        // Directed regulation cases
        reg_round(100, 2, 1, 1, 1000, 1010, 1011, "R6");
        reg_round(100, 2, 1, 1, 1000,  990,  989, "R5");
        reg_round(250, 3, 1, 1, 2000, 3000, 3000, "R7");
        reg_round(3,   3, 1, 1, 2000, 1000, 1000, "R7");
        reg_round(120, 1, 1, 1, 500,   600,  400, "R7");
        reg_round(80,  3, 0, 1, 1000,  500,  500, "R10");
        reg_round(40,  0, 0, 1, 1000, 1000, 1200, "R10");
        reg_round(40,  0, 1, 1, 1000,  800,  800, "R10");
        reg_round(60,  2, 1, 0, 1000, 1200,  700, "R4");

        // R8: sample coincident with an update waits for the next one
        enter_speed(100, 0, 1, 1, 1000);
        strobe_at(2, 2000);
        wait_to(L_FAST + 4);
        check("R8", duty_out, 101);
        strobe_at(2 * L_FAST, 2000);
        wait_to(2 * L_FAST + 5);
        check("R8", duty_out, 101);
        wait_to(3 * L_FAST + 5);
        check("R8", duty_out, 102);
        wait_to(4 * L_FAST + 5);
        check("R8", duty_out, 102);

        // R9: tach disabled in speed mode holds
        enter_speed(100, 3, 1, 1, 1000);
        strobe_at(2, 2000);
        wait_to(L_FAST + 4);
        check("R9", duty_out, 108);
        wait_to(L_FAST + 5);
        tach_en = 0;
        strobe_at(L_FAST + 6, 2000);
        wait_to(3 * L_FAST);
        check("R9", duty_out, 108);

        // Random regulation rounds
        for (int i = 0; i < 30; i++) begin
            int tgt, m1, m2, h, code;
            bit tm, fast;
            tgt = 500 + $urandom % 3000;
            m1 = tgt + int'($urandom % 41) - 20;
            m2 = tgt + int'($urandom % 41) - 20;
            h = $urandom % 256;
            code = $urandom % 4;
            tm = 1'($urandom % 2);
            fast = ($urandom % 4 == 0) ? 1'b0 : 1'b1;
            reg_round(h, code, tm, fast, tgt, m1, m2, "R5");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: duty_out=%0d expected=completion", duty_out);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule